// File: doc/BRIEF.md
# Locality Interrupt Enable and Status Unit

This block holds one interrupt-enable register and one interrupt-status register for each locality of a multi-locality command interface. All of them share a single interrupt line. The arbiter and the command engine report events on a four-bit source bundle tagged with a locality number. The four sources are data-available, status-valid, locality-changed and command-ready. An event is latched into the status register of its locality only when that locality's enables admit it. A latched event asserts the shared line.

Software reaches the registers through a simple write strobe and a combinational read port. Writes to enable and status take effect only when they come from the locality that currently owns the interface. Status bits are cleared by writing ones. A read-only vector register reports the line number chosen at build time. The line polarity seen at the pin follows the polarity field of the owning locality.

Top module: `locint_unit`

## Requirements
- R1: After reset every enable register reads 0x0000_0008 (polarity field bits 4:3 = 01), every status register reads 0, and the logical line is low, so `irqOut` is 1.
- R2: An accepted enable write stores only bit 31 (global enable), bits 4:3 (polarity) and the source enables. The source enables are bit 0 data-available, bit 1 status-valid, bit 2 locality-changed and bit 7 command-ready. Every other bit reads back 0.
- R3: An enable write changes only the byte lanes whose `wrByteEn` bit is set. Lane n covers bits 8n+7:8n.
- R4: An event sets a status bit only when bit 31 and that source's enable bit are both 1 in the target locality. The `evtSrc` bits map to status bits as 0→0, 1→1, 2→2, 3→7. Events tagged with a locality number of NUM_LOC or above are dropped.
- R5: The logical line rises on the clock edge after an event latches any status bit.
- R6: An accepted status write clears the supported status bits that are written as 1 in enabled lanes. A bit set by an event in the same cycle stays set.
- R7: The logical line falls after an accepted status write leaves that locality's status at zero, provided no event latches in the same cycle.
- R8: A write to enable or status is ignored when `wrLoc` differs from `activeLoc`, or when `activeLoc` names no locality (≥ NUM_LOC).
- R9: Register select 2 reads the build-time line number LINE_NUM (0 to 15) in bits 3:0, and writes to it have no effect. Register select 0 is enable, 1 is status, 3 reads 0.
- R10: With STS_VALID_EN = 0, bit 1 is neither stored in the enable register nor latched into the status register.
- R11: `irqOut` is the inverse of the logical line when the owning locality's polarity field is 01 or no locality owns the interface. Otherwise it equals the logical line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| activeLoc | input | 3 | Locality owning the interface; ≥ NUM_LOC means none |
| wrEn | input | 1 | Register write strobe |
| wrLoc | input | 3 | Locality issuing the write |
| wrReg | input | 2 | Register select for the write (0 enable, 1 status, 2 vector) |
| wrData | input | 32 | Write data |
| wrByteEn | input | 4 | Byte-lane enables for the write |
| evtSrc | input | 4 | Event sources: data-available, status-valid, locality-changed, command-ready |
| evtLoc | input | 3 | Locality the event is aimed at |
| rdLoc | input | 3 | Locality for the read port |
| rdReg | input | 2 | Register select for the read port |
| rdData | output | 32 | Read data |
| irqOut | output | 1 | Shared interrupt pin, polarity applied |

## Verification
The bench builds two copies side by side on the same stimulus. One has five localities, status-valid support on and line number 11. The other has status-valid support off and line number 15, the top of the legal range. Driving both at once lets every event and write show whether bit 1 is kept or dropped. It also checks both ends of the vector field. The random phase covers the rest: ownership changes, writes from localities that do not own the interface, partial byte lanes, and events that coincide with clears. It also moves the polarity field on the owning locality.

// File: rtl/locint_pkg.sv
package locint_pkg;

  localparam int LOC_W = 3;

  typedef enum logic [1:0] {
    REG_ENABLE = 2'd0,
    REG_STATUS = 2'd1,
    REG_VECTOR = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             enWr;
    logic             stClr;
    logic [LOC_W-1:0] wrLoc;
    logic             evtGo;
    logic [LOC_W-1:0] evtLoc;
    logic [3:0]       evtSrc;
  } strobe_t;

endpackage

// File: rtl/locint_ctrl.sv
module locint_ctrl
  import locint_pkg::*;
#(
  parameter int NUM_LOC = 5
) (
  input  logic [LOC_W-1:0] activeLoc,
  input  logic             wrEn,
  input  logic [LOC_W-1:0] wrLoc,
  input  reg_sel_e         wrReg,
  input  logic [3:0]       evtSrc,
  input  logic [LOC_W-1:0] evtLoc,
  output strobe_t          stb
);

  localparam logic [LOC_W-1:0] LOC_LIMIT = LOC_W'(NUM_LOC);

  logic ownerValid;
  logic writeAccepted;

  assign ownerValid    = activeLoc < LOC_LIMIT;
  assign writeAccepted = wrEn && ownerValid && (wrLoc == activeLoc);

  always_comb begin
    stb        = '0;
    stb.enWr   = writeAccepted && (wrReg == REG_ENABLE);
    stb.stClr  = writeAccepted && (wrReg == REG_STATUS);
    stb.wrLoc  = wrLoc;
    stb.evtGo  = (|evtSrc) && (evtLoc < LOC_LIMIT);
    stb.evtLoc = evtLoc;
    stb.evtSrc = evtSrc;
  end

endmodule

// File: rtl/locint_dp.sv
module locint_dp
  import locint_pkg::*;
#(
  parameter int         NUM_LOC      = 5,
  parameter logic [3:0] LINE_NUM     = 4'd11,
  parameter bit         STS_VALID_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [31:0]      wrData,
  input  logic [3:0]       wrByteEn,
  input  logic [LOC_W-1:0] activeLoc,
  input  logic [LOC_W-1:0] rdLoc,
  input  reg_sel_e         rdReg,
  output logic [31:0]      rdData,
  output logic             irqOut,
  output logic             lineLevel
);

  localparam logic [7:0]  SUP_MASK = STS_VALID_EN ? 8'h87 : 8'h85;
  localparam logic [31:0] EN_WMASK = 32'h8000_0018 | {24'h0, SUP_MASK};
  localparam logic [31:0] EN_RESET = 32'h0000_0008;
  localparam logic [1:0]  POL_LOW  = 2'b01;

  logic [NUM_LOC-1:0][31:0] enVec;
  logic [NUM_LOC-1:0][7:0]  stVec;
  logic [NUM_LOC-1:0]       setAny;
  logic [NUM_LOC-1:0]       clrZero;
  logic [31:0]              laneMask;
  logic [7:0]               srcBits;
  logic                     lineQ;
  logic [1:0]               polSel;

  assign laneMask = {{8{wrByteEn[3]}}, {8{wrByteEn[2]}},
                     {8{wrByteEn[1]}}, {8{wrByteEn[0]}}};
  assign srcBits  = {stb.evtSrc[3], 4'b0000, stb.evtSrc[2:0]};

  for (genvar i = 0; i < NUM_LOC; i++) begin : g_loc
    logic [31:0] enQ;
    logic [7:0]  stQ;
    logic [7:0]  setBits;
    logic [7:0]  clrBits;
    logic [7:0]  stNext;
    logic        wrHere;

    assign wrHere = stb.wrLoc == LOC_W'(i);

    always_comb begin
      setBits = '0;
      if (stb.evtGo && (stb.evtLoc == LOC_W'(i)))
        setBits = srcBits & enQ[7:0] & SUP_MASK & {8{enQ[31]}};
      clrBits = '0;
      if (stb.stClr && wrHere)
        clrBits = wrData[7:0] & laneMask[7:0] & SUP_MASK;
      stNext = (stQ & ~clrBits) | setBits;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ <= EN_RESET;
        stQ <= '0;
      end else begin
        if (stb.enWr && wrHere)
          enQ <= (enQ & ~(laneMask & EN_WMASK)) | (wrData & laneMask & EN_WMASK);
        stQ <= stNext;
      end
    end

    assign setAny[i]  = |setBits;
    assign clrZero[i] = stb.stClr && wrHere && (stNext == 8'h00);
    assign enVec[i]   = enQ;
    assign stVec[i]   = stQ;
  end

  // shared logical line: raised by any latch, lowered by a clear to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      lineQ <= 1'b0;
    else if (|setAny)
      lineQ <= 1'b1;
    else if (|clrZero)
      lineQ <= 1'b0;
  end

  always_comb begin
    polSel = POL_LOW;
    for (int i = 0; i < NUM_LOC; i++)
      if (activeLoc == LOC_W'(i)) polSel = enVec[i][4:3];
  end

  assign irqOut    = (polSel == POL_LOW) ? ~lineQ : lineQ;
  assign lineLevel = lineQ;

  always_comb begin
    rdData = '0;
    case (rdReg)
      REG_ENABLE: begin
        for (int i = 0; i < NUM_LOC; i++)
          if (rdLoc == LOC_W'(i)) rdData = enVec[i];
      end
      REG_STATUS: begin
        for (int i = 0; i < NUM_LOC; i++)
          if (rdLoc == LOC_W'(i)) rdData = {24'h0, stVec[i]};
      end
      REG_VECTOR: rdData = {28'h0, LINE_NUM};
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/locint_unit.sv
module locint_unit
  import locint_pkg::*;
#(
  parameter int         NUM_LOC      = 5,
  parameter logic [3:0] LINE_NUM     = 4'd11,
  parameter bit         STS_VALID_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  activeLoc,
  input  logic        wrEn,
  input  logic [2:0]  wrLoc,
  input  logic [1:0]  wrReg,
  input  logic [31:0] wrData,
  input  logic [3:0]  wrByteEn,
  input  logic [3:0]  evtSrc,
  input  logic [2:0]  evtLoc,
  input  logic [2:0]  rdLoc,
  input  logic [1:0]  rdReg,
  output logic [31:0] rdData,
  output logic        irqOut
);

  strobe_t stb;
  logic    lineLevel;

  locint_ctrl #(.NUM_LOC(NUM_LOC)) ctrl_i (
    .activeLoc (activeLoc),
    .wrEn      (wrEn),
    .wrLoc     (wrLoc),
    .wrReg     (reg_sel_e'(wrReg)),
    .evtSrc    (evtSrc),
    .evtLoc    (evtLoc),
    .stb       (stb)
  );

  locint_dp #(
    .NUM_LOC      (NUM_LOC),
    .LINE_NUM     (LINE_NUM),
    .STS_VALID_EN (STS_VALID_EN)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrData    (wrData),
    .wrByteEn  (wrByteEn),
    .activeLoc (activeLoc),
    .rdLoc     (rdLoc),
    .rdReg     (reg_sel_e'(rdReg)),
    .rdData    (rdData),
    .irqOut    (irqOut),
    .lineLevel (lineLevel)
  );

endmodule

// File: rtl/locint_unit_chk.sv
module locint_unit_chk #(
  parameter int         NUM_LOC      = 5,
  parameter logic [3:0] LINE_NUM     = 4'd11,
  parameter bit         STS_VALID_EN = 1'b1
) (
  input logic        clk,
  input logic        rstN,
  input logic [2:0]  activeLoc,
  input logic        wrEn,
  input logic [2:0]  wrLoc,
  input logic [1:0]  wrReg,
  input logic [3:0]  evtSrc,
  input logic [2:0]  evtLoc,
  input logic [1:0]  rdReg,
  input logic [31:0] rdData,
  input logic        irqOut,
  input logic        lineLevel
);

  localparam logic [31:0] KEEP = STS_VALID_EN ? 32'h8000_009F : 32'h8000_009D;

  always @(posedge clk)
    if (!rstN) p_line_idle_in_reset_r1: assert (lineLevel == 1'b0);

  p_enable_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdReg == 2'd0) |-> ((rdData & ~KEEP) == 32'h0));

  p_rise_needs_event_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineLevel) |-> $past((|evtSrc) && (evtLoc < 3'(NUM_LOC))));

  p_fall_needs_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineLevel) |-> $past(wrEn && (wrReg == 2'd1) && (wrLoc == activeLoc)
                               && (activeLoc < 3'(NUM_LOC))));

  p_vector_fixed_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rdReg == 2'd2) |-> (rdData == {28'h0, LINE_NUM}));

  p_no_owner_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    (activeLoc >= 3'(NUM_LOC)) |-> (irqOut == !lineLevel));

endmodule

bind locint_unit locint_unit_chk #(
  .NUM_LOC      (NUM_LOC),
  .LINE_NUM     (LINE_NUM),
  .STS_VALID_EN (STS_VALID_EN)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .activeLoc (activeLoc),
  .wrEn      (wrEn),
  .wrLoc     (wrLoc),
  .wrReg     (wrReg),
  .evtSrc    (evtSrc),
  .evtLoc    (evtLoc),
  .rdReg     (rdReg),
  .rdData    (rdData),
  .irqOut    (irqOut),
  .lineLevel (lineLevel)
);

// File: tb/locint_unit_tb_top.sv
`timescale 1ns/1ps
module locint_unit_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic [2:0]  activeLoc = 3'd7;
  logic        wrEn = 1'b0;
  logic [2:0]  wrLoc = 3'd0;
  logic [1:0]  wrReg = 2'd3;
  logic [31:0] wrData = '0;
  logic [3:0]  wrByteEn = 4'hF;
  logic [3:0]  evtSrc = 4'h0;
  logic [2:0]  evtLoc = 3'd0;
  logic [2:0]  rdLoc = 3'd0;
  logic [1:0]  rdReg = 2'd0;
  logic [31:0] rdA, rdB;
  logic        irqA, irqB;

  int nChecks = 0;
  int nFail   = 0;

  logic [31:0] mEn [2][5];
  logic [7:0]  mSt [2][5];
  logic        mLine [2];
  logic [2:0]  curAct = 3'd7;

  always #2.5 clk = ~clk;

  locint_unit #(.NUM_LOC(5), .LINE_NUM(4'd11), .STS_VALID_EN(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .activeLoc(activeLoc), .wrEn(wrEn), .wrLoc(wrLoc),
    .wrReg(wrReg), .wrData(wrData), .wrByteEn(wrByteEn), .evtSrc(evtSrc),
    .evtLoc(evtLoc), .rdLoc(rdLoc), .rdReg(rdReg), .rdData(rdA), .irqOut(irqA));

  locint_unit #(.NUM_LOC(5), .LINE_NUM(4'd15), .STS_VALID_EN(1'b0)) dutNoSv_i (
    .clk(clk), .rstN(rstN), .activeLoc(activeLoc), .wrEn(wrEn), .wrLoc(wrLoc),
    .wrReg(wrReg), .wrData(wrData), .wrByteEn(wrByteEn), .evtSrc(evtSrc),
    .evtLoc(evtLoc), .rdLoc(rdLoc), .rdReg(rdReg), .rdData(rdB), .irqOut(irqB));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic expIrq(input int c);
    logic [1:0] pol = 2'b01;
    if (curAct < 5) pol = mEn[c][curAct][4:3];
    return (pol == 2'b01) ? !mLine[c] : mLine[c];
  endfunction

  task automatic modelReset();
    for (int c = 0; c < 2; c++) begin
      mLine[c] = 1'b0;
      for (int i = 0; i < 5; i++) begin
        mEn[c][i] = 32'h0000_0008;
        mSt[c][i] = 8'h00;
      end
    end
  endtask

  task automatic step(input logic [2:0] act, input logic we, input logic [2:0] wl,
                      input logic [1:0] wr, input logic [31:0] wd, input logic [3:0] be,
                      input logic [3:0] es, input logic [2:0] el);
    logic [31:0] nEn [2][5];
    logic [7:0]  nSt [2][5];
    logic        nLine [2];
    @(negedge clk);
    activeLoc = act; wrEn = we; wrLoc = wl; wrReg = wr; wrData = wd;
    wrByteEn = be; evtSrc = es; evtLoc = el;
    for (int c = 0; c < 2; c++) begin
      logic [7:0]  sup  = (c == 0) ? 8'h87 : 8'h85;
      logic [31:0] wm   = 32'h8000_0018 | {24'h0, sup};
      logic [31:0] lane = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
      logic        acc  = we && (act < 5) && (wl == act);
      logic        anySet = 1'b0;
      logic        anyZero = 1'b0;
      for (int i = 0; i < 5; i++) begin
        logic [7:0] setB = 8'h00;
        logic [7:0] clrB = 8'h00;
        logic       clrW = acc && (wr == 2'd1) && (wl == 3'(i));
        if ((es != 4'h0) && (el == 3'(i)))
          setB = {es[3], 4'b0000, es[2:0]} & mEn[c][i][7:0] & sup & {8{mEn[c][i][31]}};
        if (clrW) clrB = wd[7:0] & lane[7:0] & sup;
        nSt[c][i] = (mSt[c][i] & ~clrB) | setB;
        if (setB != 8'h00) anySet = 1'b1;
        if (clrW && (nSt[c][i] == 8'h00)) anyZero = 1'b1;
        if (acc && (wr == 2'd0) && (wl == 3'(i)))
          nEn[c][i] = (mEn[c][i] & ~(lane & wm)) | (wd & lane & wm);
        else
          nEn[c][i] = mEn[c][i];
      end
      nLine[c] = anySet ? 1'b1 : (anyZero ? 1'b0 : mLine[c]);
    end
    @(posedge clk);
    #1;
    for (int c = 0; c < 2; c++) begin
      mLine[c] = nLine[c];
      for (int i = 0; i < 5; i++) begin
        mEn[c][i] = nEn[c][i];
        mSt[c][i] = nSt[c][i];
      end
    end
    curAct = act;
  endtask

  task automatic checkState(input string tag);
    for (int l = 0; l < 5; l++) begin
      rdLoc = 3'(l);
      rdReg = 2'd0; #0.1;
      chk({tag, " enable"}, rdA, mEn[0][l]);
      chk({tag, " enable/no-sv"}, rdB, mEn[1][l]);
      rdReg = 2'd1; #0.1;
      chk({tag, " status"}, rdA, {24'h0, mSt[0][l]});
      chk({tag, " status/no-sv"}, rdB, {24'h0, mSt[1][l]});
    end
    chk({tag, " irq"}, {31'h0, irqA}, {31'h0, expIrq(0)});
    chk({tag, " irq/no-sv"}, {31'h0, irqB}, {31'h0, expIrq(1)});
  endtask

  task automatic checkVector(input string tag);
    rdReg = 2'd2; #0.1;
    chk(tag, rdA, 32'd11);
    chk(tag, rdB, 32'd15);
  endtask

  task automatic idle(input logic [2:0] act);
    step(act, 1'b0, 3'd0, 2'd3, 32'h0, 4'h0, 4'h0, 3'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelReset();
    #1 rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #0.5;
    // R1: reset values and idle pin
    checkState("R1");
    chk("R1 enable reset", mEn[0][0], 32'h0000_0008);
    // R9: vector read and ignored write
    checkVector("R9");
    step(3'd2, 1'b1, 3'd2, 2'd2, 32'hFFFF_FFFF, 4'hF, 4'h0, 3'd0);
    checkVector("R9 after write");
    // R2 and R10: full enable write, masked bits
    step(3'd2, 1'b1, 3'd2, 2'd0, 32'hFFFF_FFFF, 4'hF, 4'h0, 3'd0);
    checkState("R2");
    chk("R2 kept bits", mEn[0][2], 32'h8000_009F);
    chk("R10 kept bits", mEn[1][2], 32'h8000_009D);
    // R10: status-valid event only latched in the full build
    step(3'd2, 1'b0, 3'd0, 2'd3, 32'h0, 4'h0, 4'b0010, 3'd2);
    checkState("R10");
    // R4 R5: all sources
    step(3'd2, 1'b0, 3'd0, 2'd3, 32'h0, 4'h0, 4'b1111, 3'd2);
    checkState("R4");
    idle(3'd2);
    checkState("R5");
    // R8: writes from a non-owner or with no owner
    step(3'd2, 1'b1, 3'd1, 2'd1, 32'hFF, 4'hF, 4'h0, 3'd0);
    checkState("R8");
    step(3'd2, 1'b1, 3'd1, 2'd0, 32'h0, 4'hF, 4'h0, 3'd0);
    checkState("R8 enable");
    step(3'd7, 1'b1, 3'd2, 2'd1, 32'hFF, 4'hF, 4'h0, 3'd0);
    checkState("R8 no owner");
    // R6: partial clear, then clear coinciding with an event
    step(3'd2, 1'b1, 3'd2, 2'd1, 32'h01, 4'hF, 4'h0, 3'd0);
    checkState("R6");
    step(3'd2, 1'b1, 3'd2, 2'd1, 32'h84, 4'hF, 4'b0001, 3'd2);
    checkState("R6 set wins");
    step(3'd2, 1'b1, 3'd2, 2'd1, 32'hFF, 4'hE, 4'h0, 3'd0);
    checkState("R6 lane off");
    // R7: clear to zero drops the line
    step(3'd2, 1'b1, 3'd2, 2'd1, 32'hFF, 4'hF, 4'h0, 3'd0);
    checkState("R7");
    // R3: byte-lane write
    step(3'd2, 1'b1, 3'd2, 2'd0, 32'h0000_0000, 4'b0001, 4'h0, 3'd0);
    checkState("R3");
    chk("R3 upper lane kept", mEn[0][2], 32'h8000_0000);
    step(3'd2, 1'b0, 3'd0, 2'd3, 32'h0, 4'h0, 4'b1111, 3'd2);
    checkState("R4 sources off");
    // R11: low-level polarity, then no owner
    step(3'd2, 1'b1, 3'd2, 2'd0, 32'h0000_008F, 4'b0001, 4'h0, 3'd0);
    step(3'd2, 1'b0, 3'd0, 2'd3, 32'h0, 4'h0, 4'b1000, 3'd2);
    checkState("R11");
    idle(3'd7);
    checkState("R11 no owner");
    // R4: global enable off, and an out-of-range locality tag
    step(3'd2, 1'b1, 3'd2, 2'd0, 32'h0, 4'b1000, 4'h0, 3'd0);
    step(3'd2, 1'b0, 3'd0, 2'd3, 32'h0, 4'h0, 4'b1111, 3'd2);
    checkState("R4 global off");
    step(3'd2, 1'b0, 3'd0, 2'd3, 32'h0, 4'h0, 4'b1111, 3'd6);
    checkState("R4 bad locality");
    // random phase
    for (int n = 0; n < 600; n++) begin
      logic [2:0]  act = 3'($urandom_range(0, 6));
      logic [2:0]  wl  = ($urandom_range(0, 9) < 7) ? act : 3'($urandom_range(0, 5));
      logic [31:0] wd  = $urandom;
      if ($urandom_range(0, 1) == 1) wd[31] = 1'b1;
      step(act, 1'($urandom_range(0, 1)), wl, 2'($urandom_range(0, 3)), wd,
           4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
           3'($urandom_range(0, 5)));
      checkState("random");
    end
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule